// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block models a synchronous static RAM whose data path is flow-through: every address, data and control input is captured on the rising clock edge, and the stored word for a read leaves the array on the cycle right after its address was captured, with no output register in between. Words are built from byte lanes. Each lane holds eight data bits and a parity bit. A write can update any subset of lanes, or all of them at once through a global write input. Depth, lane count and lane width are parameters, so the block stays small in simulation.

An access opens with one of two address strobes. The processor-side strobe needs only the main select, and it always opens a read. The controller-side strobe needs all three selects, and it opens a read or a write depending on the write controls. Once a burst is open, the two low address bits seed a 2-bit step counter. The counter moves forward only on cycles where the advance input is high, and it visits the four words either in linear order or in interleaved order. A strobe that arrives without its selects closes the burst in one cycle. The sleep input blocks every access and turns the bus drivers off, and it keeps the stored data. The shared data bus is presented as separate input, output and output-enable signals, which the pad ring joins together.

Top module: `fts_burst_ram`

## Requirements
- R1: A read opened or continued at clock edge k drives the addressed word on `dq_out` and raises `dq_oe` from edge k until edge k+1, with no extra register delay.
- R2: `astb_cpu` together with `sel_main` opens a read at `addr`, whatever the states of `sel_aux1` and `sel_aux2`.
- R3: `astb_ctl` opens an access only when `sel_main`, `sel_aux1` and `sel_aux2` are all high. The access is a write when the write controls request any lane, and a read otherwise.
- R4: When `astb_cpu` and `astb_ctl` are both qualified in the same cycle, the processor strobe wins. The cycle is a read, and nothing is written even if write controls are asserted.
- R5: Opening a burst loads the step counter with 0 and the start offset with `addr[1:0]`. A continuation cycle with `adv` high moves the step forward by one, modulo 4. With `adv` low the address holds.
- R6: The low two address bits are `(start + step) mod 4` when `burst_ilv`=0, and `start XOR step` when `burst_ilv`=1. The upper bits come from `addr` at the start of the burst.
- R7: `gwr`=1 writes all lanes, whatever `bwen` and `bsel` say.
- R8: When `gwr`=0, lane i (bits `[9i+8:9i]`) is written only when `bwen`=1 and `bsel[i]`=1. Other lanes keep their contents. If `bwen`=0 the cycle is a read.
- R9: A cycle with a strobe that is not qualified ends the burst. `dq_oe` is low in the next cycle, and later cycles without a strobe neither read nor write.
- R10: While `sleep`=1 there is no read and no write, `dq_oe` is low, and the open burst is dropped. Stored data is kept.
- R11: `dq_oe` is high only during a read cycle while `oe`=1. It is low after reset, during write cycles and while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state (array not cleared) |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| astb_cpu | input | 1 | Processor-side address strobe, always opens a read |
| astb_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Moves the burst step forward on a continuation cycle |
| gwr | input | 1 | Global write: all lanes |
| bwen | input | 1 | Enables the per-lane write strobes |
| bsel | input | LANES | Per-lane write strobes |
| sel_main | input | 1 | Main select, qualifies both strobes |
| sel_aux1 | input | 1 | Second select, qualifies the controller strobe |
| sel_aux2 | input | 1 | Third select, qualifies the controller strobe |
| oe | input | 1 | Output enable |
| sleep | input | 1 | Blocks all access and the bus drivers |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, valid when dq_oe is high |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Two clashes are provoked. In the first, both address strobes are qualified in one cycle while a global write and fresh data are presented. The bench expects a read of the old word that cycle, and it confirms with a later read that the word was not changed. In the second, sleep is raised in the same cycle as a qualified controller write and an advance. The bench expects the bus to stay off, nothing to be written, and the burst to be gone, so a following strobe-less write is also ignored. Both cases are judged by a behavioural model that is compared against the bus on every clock.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STEP_W = 2;

  // Decision taken for the current clock edge
  typedef enum logic [2:0] {
    CYC_NONE,      // no burst open, no strobe
    CYC_DROP,      // sleep or unqualified strobe: burst closed
    CYC_START_RD,  // processor strobe: forced read
    CYC_START_CTL, // controller strobe: read or write
    CYC_CONT       // continuation of an open burst
  } cyc_e;

  // Low address bits of a burst beat
  function automatic logic [STEP_W-1:0] burst_low(
      input logic [STEP_W-1:0] start,
      input logic [STEP_W-1:0] step,
      input logic              ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             astb_cpu,
  input  logic             astb_ctl,
  input  logic             sel_main,
  input  logic             sel_aux1,
  input  logic             sel_aux2,
  input  logic             adv,
  input  logic             gwr,
  input  logic             bwen,
  input  logic [LANES-1:0] bsel,
  input  logic             sleep,
  output logic             ev_load,
  output logic             ev_step,
  output logic [LANES-1:0] lane_we,
  output logic             rd_phase
);

  logic             qual_cpu, qual_ctl, stray;
  logic [LANES-1:0] req_mask;
  logic             access;
  logic             active_q;
  cyc_e             cyc;

  assign qual_cpu = astb_cpu & sel_main;
  assign qual_ctl = astb_ctl & sel_main & sel_aux1 & sel_aux2;
  assign stray    = (astb_cpu | astb_ctl) & ~qual_cpu & ~qual_ctl;
  assign req_mask = gwr ? {LANES{1'b1}} : (bwen ? bsel : '0);

  always_comb begin
    if (sleep)         cyc = CYC_DROP;
    else if (qual_cpu) cyc = CYC_START_RD;
    else if (qual_ctl) cyc = CYC_START_CTL;
    else if (stray)    cyc = CYC_DROP;
    else if (active_q) cyc = CYC_CONT;
    else               cyc = CYC_NONE;
  end

  assign ev_load = (cyc == CYC_START_RD) || (cyc == CYC_START_CTL);
  assign ev_step = (cyc == CYC_CONT) && adv;
  assign lane_we = ((cyc == CYC_START_CTL) || (cyc == CYC_CONT)) ? req_mask : '0;
  assign access  = ev_load || (cyc == CYC_CONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_phase <= 1'b0;
    end else begin
      active_q <= access;
      rd_phase <= access && (lane_we == '0);
    end
  end

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0) && !ev_load);

  // R10
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !active_q && !rd_phase);

  // R4
  cpu_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_cpu && sel_main && !sleep) |=> rd_phase);

  // R9
  stray_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((astb_cpu || astb_ctl) && !sel_main && !sleep) |=> !active_q && !rd_phase);

  // R3
  ctl_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_ctl && !astb_cpu && !(sel_main && sel_aux1 && sel_aux2)) |=> !active_q);

endmodule

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:STEP_W] hi_q, hi_d;
  logic [STEP_W-1:0]      start_q, start_d, step_q, step_d;

  always_comb begin
    hi_d    = hi_q;
    start_d = start_q;
    step_d  = step_q;
    if (ev_load) begin
      hi_d    = addr_in[ADDR_W-1:STEP_W];
      start_d = addr_in[STEP_W-1:0];
      step_d  = '0;
    end else if (ev_step) begin
      step_d  = step_q + 1'b1;
    end
  end

  assign nxt_addr = {hi_d, burst_low(start_d, step_d, ilv)};
  assign cur_addr = {hi_q, burst_low(start_q, step_q, ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      step_q  <= '0;
    end else begin
      hi_q    <= hi_d;
      start_q <= start_d;
      step_q  <= step_d;
    end
  end

  // R5
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cur_addr == $past(addr_in)) && (step_q == '0));

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_load) |=> step_q == $past(step_q) + 1'b1);

  // R5
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_step && !ev_load) |=> $stable(step_q) && $stable(hi_q));

endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) store[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = store[raddr];
  end

endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    astb_cpu,
  input  logic                    astb_ctl,
  input  logic                    adv,
  input  logic                    gwr,
  input  logic                    bwen,
  input  logic [LANES-1:0]        bsel,
  input  logic                    sel_main,
  input  logic                    sel_aux1,
  input  logic                    sel_aux2,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    burst_ilv,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  logic              ev_load, ev_step, rd_phase;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] nxt_addr, cur_addr;
  logic [WORD_W-1:0] rd_word;

  fts_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .astb_cpu (astb_cpu),
    .astb_ctl (astb_ctl),
    .sel_main (sel_main),
    .sel_aux1 (sel_aux1),
    .sel_aux2 (sel_aux2),
    .adv      (adv),
    .gwr      (gwr),
    .bwen     (bwen),
    .bsel     (bsel),
    .sleep    (sleep),
    .ev_load  (ev_load),
    .ev_step  (ev_step),
    .lane_we  (lane_we),
    .rd_phase (rd_phase)
  );

  fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_load  (ev_load),
    .ev_step  (ev_step),
    .ilv      (burst_ilv),
    .addr_in  (addr),
    .nxt_addr (nxt_addr),
    .cur_addr (cur_addr)
  );

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (nxt_addr),
    .wdata (dq_in),
    .raddr (cur_addr),
    .rdata (rd_word)
  );

  // Flow-through: array output goes straight to the bus
  assign dq_out = rd_word;
  assign dq_oe  = rd_phase & oe & ~sleep;

  // R11
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |=> !dq_oe);

  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_cpu && sel_main && !sleep) |=> (dq_oe == (oe && !sleep)));

endmodule

// File: tb/fts_burst_ram_test.sv
`timescale 1ns/1ps
module fts_burst_ram_test;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic        astb_cpu = 0, astb_ctl = 0, adv = 0, gwr = 0, bwen = 0;
  logic [3:0]  bsel = '0;
  logic        sel_main = 1, sel_aux1 = 1, sel_aux2 = 1, oe = 1, sleep = 0, burst_ilv = 0;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic        dq_oe;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [35:0] rm [NW];
  bit m_act = 0, m_rd = 0;
  int m_base = 0, m_s = 0, m_n = 0, m_cur = 0;

  fts_burst_ram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .astb_cpu(astb_cpu), .astb_ctl(astb_ctl),
    .adv(adv), .gwr(gwr), .bwen(bwen), .bsel(bsel), .sel_main(sel_main),
    .sel_aux1(sel_aux1), .sel_aux2(sel_aux2), .oe(oe), .sleep(sleep),
    .burst_ilv(burst_ilv), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  function automatic logic [35:0] pat(input int a);
    return (36'h1_0203_0405 * a) ^ 36'h9_5A5A_5A5A;
  endfunction

  function automatic int beat_addr();
    int lo;
    lo = burst_ilv ? (m_s ^ m_n) : ((m_s + m_n) % 4);
    return (m_base & ~3) | lo;
  endfunction

  task automatic model_write();
    logic [3:0] m;
    m = gwr ? 4'hF : (bwen ? bsel : 4'h0);
    for (int i = 0; i < 4; i++)
      if (m[i]) rm[m_cur][i*9 +: 9] = dq_in[i*9 +: 9];
    m_rd = (m == 4'h0);
  endtask

  task automatic model_step();
    bit qc, qt;
    qc = astb_cpu && sel_main;
    qt = astb_ctl && sel_main && sel_aux1 && sel_aux2;
    if (!rst_n) begin
      m_act = 0; m_rd = 0;
    end else if (sleep) begin
      m_act = 0; m_rd = 0;
    end else if (qc || qt) begin
      m_base = addr; m_s = addr % 4; m_n = 0; m_cur = addr; m_act = 1;
      if (qc) m_rd = 1;
      else model_write();
    end else if (astb_cpu || astb_ctl) begin
      m_act = 0; m_rd = 0;
    end else if (m_act) begin
      if (adv) m_n = (m_n + 1) % 4;
      m_cur = beat_addr();
      model_write();
    end else begin
      m_rd = 0;
    end
  endtask

  task automatic compare(input string tag);
    logic exp_oe;
    exp_oe = m_rd && oe && !sleep;
    vectors++;
    if (dq_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: dq_oe=%b expected %b", tag, dq_oe, exp_oe);
    end else if (exp_oe && dq_out !== rm[m_cur]) begin
      fails++;
      $display("FAIL %s: dq_out=%h expected %h (addr %0d)", tag, dq_out, rm[m_cur], m_cur);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic clear_ctl();
    astb_cpu = 0; astb_ctl = 0; adv = 0; gwr = 0; bwen = 0; bsel = '0;
  endtask

  task automatic cpu_rd(input int a, input string tag);
    clear_ctl(); astb_cpu = 1; addr = a[AW-1:0];
    tick(tag);
    astb_cpu = 0;
  endtask

  task automatic ctl_op(input int a, input bit g, input bit be, input logic [3:0] bs,
                        input logic [35:0] d, input string tag);
    clear_ctl(); astb_ctl = 1; addr = a[AW-1:0]; gwr = g; bwen = be; bsel = bs; dq_in = d;
    tick(tag);
    clear_ctl();
  endtask

  task automatic cont(input bit ad, input bit g, input bit be, input logic [3:0] bs,
                      input logic [35:0] d, input string tag);
    clear_ctl(); adv = ad; gwr = g; bwen = be; bsel = bs; dq_in = d;
    tick(tag);
    clear_ctl();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R11: reset state
    repeat (3) tick("R11 reset");
    rst_n = 1;
    tick("R11 idle after reset");

    // R7: fill with global write, byte controls off
    for (int a = 0; a < NW; a++) ctl_op(a, 1, 0, 4'h0, pat(a), "R7 fill");
    tick("R11 idle");

    // R1 R5 R6: linear burst from offset 1, wraps after four steps
    burst_ilv = 0;
    cpu_rd(13, "R1 cpu read");
    for (int k = 0; k < 5; k++) cont(1, 0, 0, 4'h0, '0, "R6 linear step");
    cont(0, 0, 0, 4'h0, '0, "R5 hold");
    cont(0, 0, 0, 4'h0, '0, "R5 hold");
    cont(1, 0, 0, 4'h0, '0, "R5 step after hold");

    // R6: interleaved burst from offset 2
    tick("R11 idle");
    burst_ilv = 1;
    tick("R11 idle");
    cpu_rd(22, "R2 cpu read");
    for (int k = 0; k < 4; k++) cont(1, 0, 0, 4'h0, '0, "R6 interleaved step");
    cpu_rd(45, "R2 cpu read");
    for (int k = 0; k < 3; k++) cont(1, 0, 0, 4'h0, '0, "R6 interleaved step");
    tick("R11 idle");
    burst_ilv = 0;
    tick("R11 idle");

    // R8: byte writes
    ctl_op(5, 0, 1, 4'b0101, 36'hF_EDCB_A987, "R8 lane write start");
    cont(1, 0, 1, 4'b1000, 36'h1_2345_6789, "R8 lane 3 only");
    cont(1, 0, 0, 4'b1111, 36'h0_0000_0000, "R8 bwen off reads");
    cont(1, 0, 1, 4'b0010, 36'hA_AAAA_AAAA, "R8 lane 1 only");
    cpu_rd(4, "R8 readback");
    for (int k = 0; k < 3; k++) cont(1, 0, 0, 4'h0, '0, "R8 readback");
    ctl_op(9, 0, 0, 4'b1111, 36'h5_5555_5555, "R3 ctl read, bwen off");
    cont(0, 1, 0, 4'h0, 36'h3_3333_3333, "R7 global write in burst");
    cont(0, 0, 0, 4'h0, '0, "R7 readback");

    // R4: both strobes with global write: read wins, no write
    clear_ctl(); astb_cpu = 1; astb_ctl = 1; gwr = 1; bwen = 1; bsel = 4'hF;
    addr = 40; dq_in = 36'h0_DEAD_BEEF;
    tick("R4 strobe clash");
    cont(0, 0, 0, 4'h0, '0, "R4 word unchanged");
    cpu_rd(40, "R4 word unchanged");

    // R9: unqualified processor strobe closes the burst
    cpu_rd(8, "R2 cpu read");
    clear_ctl(); astb_cpu = 1; sel_main = 0; addr = 8;
    tick("R9 stray strobe");
    sel_main = 1;
    cont(1, 1, 0, 4'h0, 36'h7_7777_7777, "R9 write ignored");
    cont(0, 1, 0, 4'h0, 36'h7_7777_7777, "R9 write ignored");
    cpu_rd(8, "R9 word unchanged");
    cont(1, 0, 0, 4'h0, '0, "R9 next word unchanged");

    // R3: controller strobe with one select off
    sel_aux2 = 0;
    ctl_op(20, 1, 0, 4'h0, 36'h0_1111_1111, "R3 unqualified ctl");
    cont(0, 1, 0, 4'h0, 36'h0_1111_1111, "R3 nothing open");
    // R2: processor strobe needs only the main select
    sel_aux1 = 0;
    cpu_rd(20, "R2 read with aux selects off");
    sel_aux1 = 1; sel_aux2 = 1;

    // R11: output enable and write cycles
    cpu_rd(33, "R1 cpu read");
    oe = 0;
    cont(1, 0, 0, 4'h0, '0, "R11 oe low");
    oe = 1;
    cont(1, 0, 0, 4'h0, '0, "R11 oe back");
    cont(1, 1, 0, 4'h0, 36'h2_4680_1357, "R11 write cycle");
    cont(0, 0, 0, 4'h0, '0, "R11 read after write");

    // R10: sleep during a burst with a qualified write and advance
    cpu_rd(30, "R1 cpu read");
    clear_ctl(); sleep = 1; astb_ctl = 1; gwr = 1; adv = 1; addr = 30; dq_in = '0;
    tick("R10 sleep blocks");
    sleep = 0;
    cont(1, 1, 0, 4'h0, '0, "R10 burst dropped");
    cpu_rd(30, "R10 contents kept");
    cont(1, 0, 0, 4'h0, '0, "R10 contents kept");
    sleep = 1;
    tick("R10 bus off");
    sleep = 0;
    tick("R10 idle");

    // R1: random mix against the model
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      astb_cpu = (r < 8);
      astb_ctl = (r >= 6 && r < 20);
      addr     = AW'($urandom_range(0, NW - 1));
      adv      = $urandom_range(0, 1);
      gwr      = ($urandom_range(0, 9) == 0);
      bwen     = ($urandom_range(0, 3) == 0);
      bsel     = 4'($urandom_range(0, 15));
      sel_main = ($urandom_range(0, 19) != 0);
      sel_aux1 = ($urandom_range(0, 19) != 0);
      sel_aux2 = ($urandom_range(0, 19) != 0);
      oe       = ($urandom_range(0, 9) != 0);
      sleep    = ($urandom_range(0, 29) == 0);
      dq_in    = {4'($urandom()), 32'($urandom())};
      tick("R1 random mix");
    end
    clear_ctl(); sleep = 0; oe = 1; sel_main = 1; sel_aux1 = 1; sel_aux2 = 1;
    tick("R11 idle");

    done = 1;
    summary();
    $finish;
  end

endmodule